// File: doc/BRIEF.md
# Programmable Counter/Timer

This block is a 16-bit down/up counter that serves one serial channel in several roles. Software picks one of five modes, loads a preset, and sets the run bit. In the generator modes the counter reloads on each terminal count. It then yields a periodic pulse and a square wave that the channel can use as a bit clock. What advances the counter depends on the mode: the system clock, a prescaled system clock, edges on an external count pin, or character strobes from the receiver or transmitter.

In one-shot delay mode the counter fires once and stops. In measurement mode it times the interval between successive receive-data transitions and latches each interval into a capture register. Every terminal count sets a sticky status bit, which can raise an interrupt. When block transfers are active, a terminal count can also request the end of the current frame.

Top module: `ctimer`

## Requirements
- R1: After reset, the control, count, capture and status reads return 0, and tc_o, irq_o, clk_out_o and frame_end_o are low.
- R2: Modes 0 (rate), 1 (event) and 2 (character) share one counting rule. Writing control (address 0) with run bit 8 set loads the preset (address 1) into the count (read at address 2). Each count tick then decrements it. A tick while the count is 0 reloads the preset and pulses tc_o for one cycle, one cycle after that edge. With the system clock as source, terminal counts occur preset+1 cycles apart, and the first comes preset+1 cycles after the start write.
- R3: clk_out_o is cleared by a start write and inverts on every terminal count.
- R4: Clock source field bits 4:3 selects the tick: 0 or 3 is every system cycle, 1 is one cycle in PRESCALE, and 2 is the external pin. With source 1, terminal counts are (preset+1)*PRESCALE cycles apart.
- R5: Mode 1 ticks once per rising edge of ext_clk_i. That input passes a two-stage synchronizer, so it may toggle at most once every two system cycles.
- R6: Mode 2 ticks on rx_char_i pulses when bit 5 is 0 and on tx_char_i pulses when bit 5 is 1. The other strobe has no effect.
- R7: Mode 3 is a one-shot. It gives exactly one terminal count, preset+1 ticks after start, and then holds the count at 0.
- R8: Mode 4 ignores the first rxd_i transition after start. From then on, every transition latches the number of ticks since the previous transition into the capture register (address 3) and pulses tc_o. The count saturates at 0xFFFF. A transition on the same cycle as a tick does not count that tick.
- R9: Each terminal count sets status bit 0 (address 4) one cycle after tc_o. Writing 1 to that bit clears it. A set and a clear that land on the same edge leave the bit set.
- R10: irq_o is high exactly when status bit 0 and the interrupt enable (control bit 6) are both set.
- R11: frame_end_o pulses together with tc_o when control bit 7 is set and dma_active_i is high. Otherwise it stays low.
- R12: A control write with bit 8 clear freezes the count. A preset write during a run takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | W | Write data |
| rdata_o | output | W | Read data for addr_i |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| rxd_i | input | 1 | Receive data line for interval measurement |
| rx_char_i | input | 1 | One-cycle strobe per received character |
| tx_char_i | input | 1 | One-cycle strobe per transmitted character |
| dma_active_i | input | 1 | Block transfer in progress |
| tc_o | output | 1 | Terminal-count pulse |
| irq_o | output | 1 | Interrupt request |
| clk_out_o | output | 1 | Square-wave clock output |
| frame_end_o | output | 1 | Frame-terminate request |

## Verification
Two things can land on the same clock edge: the hardware setting the sticky status bit after a terminal count, and software clearing that bit with a write. The bench runs a preset of 3 on the system clock, so the schedule of terminal counts is known in advance. It then times a write-1-to-clear so that it lands on the exact edge where the status bit is being set. The bit must read back as set, with irq_o high. A second clear one cycle later must leave both low.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [2:0] {
    M_RATE  = 3'd0,
    M_EVENT = 3'd1,
    M_CHAR  = 3'd2,
    M_DELAY = 3'd3,
    M_MEAS  = 3'd4
  } ct_mode_e;

  typedef enum logic [1:0] {
    CS_SYS  = 2'd0,
    CS_PRE  = 2'd1,
    CS_EXT  = 2'd2,
    CS_SYS2 = 2'd3
  } ct_src_e;

  typedef struct packed {
    logic     run;
    logic     dma_en;
    logic     irq_en;
    logic     char_tx;
    ct_src_e  src;
    ct_mode_e mode;
  } ct_ctrl_t;

  localparam int CTRL_W = $bits(ct_ctrl_t);

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_PRESET = 3'd1;
  localparam logic [2:0] A_COUNT  = 3'd2;
  localparam logic [2:0] A_CAPT   = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;
endpackage

// File: rtl/ct_tick.sv
module ct_tick
  import ct_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     ext_clk_i,
  input  ct_mode_e mode_i,
  input  ct_src_e  src_i,
  input  logic     char_tx_i,
  input  logic     rx_char_i,
  input  logic     tx_char_i,
  output logic     tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  // synchronizer stages plus one history stage for edge detect
  logic [SYNC_STAGES:0] ext_sh;
  logic ext_rise;
  logic pre_tick;
  logic src_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_sh <= '0;
    else         ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk_i};
  end
  assign ext_rise = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];

  generate
    if (PRESCALE > 1) begin : g_pre
      logic [PW-1:0] pcnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          pcnt_q <= '0;
        else if (pcnt_q == PW'(PRESCALE - 1)) pcnt_q <= '0;
        else                                  pcnt_q <= pcnt_q + 1'b1;
      end
      assign pre_tick = (pcnt_q == PW'(PRESCALE - 1));

      a_r4_presc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_tick |=> !pre_tick);
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      CS_PRE:  src_tick = pre_tick;
      CS_EXT:  src_tick = ext_rise;
      default: src_tick = 1'b1;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      M_EVENT: tick_o = ext_rise;
      M_CHAR:  tick_o = char_tx_i ? tx_char_i : rx_char_i;
      default: tick_o = src_tick;
    endcase
  end
endmodule

// File: rtl/ct_core.sv
module ct_core
  import ct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         run_i,
  input  ct_mode_e     mode_i,
  input  logic         tick_i,
  input  logic         rxd_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         tc_o,
  output logic         clk_out_o
);
  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic tc_q, tc_d, clk_q, clk_d;
  logic done_q, done_d, armed_q, armed_d, rxd_q;
  logic rxd_edge;

  assign rxd_edge = rxd_i ^ rxd_q;

  always_comb begin
    cnt_d   = cnt_q;
    cap_d   = cap_q;
    tc_d    = 1'b0;
    done_d  = done_q;
    armed_d = armed_q;
    if (start_i) begin
      cnt_d   = (mode_i == M_MEAS) ? '0 : preset_i;
      done_d  = 1'b0;
      armed_d = 1'b0;
    end else if (run_i) begin
      unique case (mode_i)
        M_MEAS: begin
          if (rxd_edge) begin
            if (armed_q) begin
              cap_d = cnt_q;
              tc_d  = 1'b1;
            end
            cnt_d   = '0;
            armed_d = 1'b1;
          end else if (tick_i && armed_q && cnt_q != '1) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        M_DELAY: begin
          if (tick_i && !done_q) begin
            if (cnt_q == '0) begin
              tc_d   = 1'b1;
              done_d = 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        M_RATE, M_EVENT, M_CHAR: begin
          if (tick_i) begin
            if (cnt_q == '0) begin
              tc_d  = 1'b1;
              cnt_d = preset_i;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    clk_d = start_i ? 1'b0 : (clk_q ^ tc_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_q   <= '0;
      tc_q    <= 1'b0;
      clk_q   <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
      rxd_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      cap_q   <= cap_d;
      tc_q    <= tc_d;
      clk_q   <= clk_d;
      done_q  <= done_d;
      armed_q <= armed_d;
      rxd_q   <= rxd_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign cap_o     = cap_q;
  assign tc_o      = tc_q;
  assign clk_out_o = clk_q;

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_q && !$past(start_i) && ($past(mode_i) inside {M_RATE, M_EVENT, M_CHAR}))
      |-> cnt_q == $past(preset_i));

  a_r3_clk_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_q && !$past(start_i)) |-> clk_q != $past(clk_q));

  a_r7_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_DELAY && done_q && !start_i) |=> !tc_q);

  a_r8_capture_with_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_q) |-> tc_q);
endmodule

// File: rtl/ctimer.sv
module ctimer
  import ct_pkg::*;
#(
  parameter int W        = 16,
  parameter int PRESCALE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         ext_clk_i,
  input  logic         rxd_i,
  input  logic         rx_char_i,
  input  logic         tx_char_i,
  input  logic         dma_active_i,
  output logic         tc_o,
  output logic         irq_o,
  output logic         clk_out_o,
  output logic         frame_end_o
);
  ct_ctrl_t     ctrl_q, ctrl_wr, ctrl_eff;
  logic [W-1:0] preset_q, cnt, cap;
  logic         sticky_q, tick, tc, start, ctrl_we;

  assign ctrl_we  = wr_en_i && addr_i == A_CTRL;
  assign ctrl_wr  = ct_ctrl_t'(wdata_i[CTRL_W-1:0]);
  assign ctrl_eff = ctrl_we ? ctrl_wr : ctrl_q;
  assign start    = ctrl_we && ctrl_wr.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      preset_q <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wr;
      if (wr_en_i && addr_i == A_PRESET) preset_q <= wdata_i;
      if (tc) sticky_q <= 1'b1;
      else if (wr_en_i && addr_i == A_STAT && wdata_i[0]) sticky_q <= 1'b0;
    end
  end

  ct_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk_i),
    .mode_i    (ctrl_q.mode),
    .src_i     (ctrl_q.src),
    .char_tx_i (ctrl_q.char_tx),
    .rx_char_i (rx_char_i),
    .tx_char_i (tx_char_i),
    .tick_o    (tick)
  );

  ct_core #(.W(W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .run_i     (ctrl_q.run),
    .mode_i    (ctrl_eff.mode),
    .tick_i    (tick),
    .rxd_i     (rxd_i),
    .preset_i  (preset_q),
    .cnt_o     (cnt),
    .cap_o     (cap),
    .tc_o      (tc),
    .clk_out_o (clk_out_o)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:   rdata_o = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_PRESET: rdata_o = preset_q;
      A_COUNT:  rdata_o = cnt;
      A_CAPT:   rdata_o = cap;
      A_STAT:   rdata_o = {{(W-1){1'b0}}, sticky_q};
      default:  rdata_o = '0;
    endcase
  end

  assign tc_o        = tc;
  assign irq_o       = sticky_q & ctrl_q.irq_en;
  assign frame_end_o = tc & ctrl_q.dma_en & dma_active_i;

  a_r9_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc |=> sticky_q);
endmodule

// File: tb/sim_ctimer.sv
module sim_ctimer;
  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ext_clk = 1'b0, rxd = 1'b0, rx_ch = 1'b0, tx_ch = 1'b0, dma_act = 1'b0;
  logic        tc, irq, clk_out, fend;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctimer #(.W(16), .PRESCALE(PRESC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_clk_i(ext_clk), .rxd_i(rxd), .rx_char_i(rx_ch),
    .tx_char_i(tx_ch), .dma_active_i(dma_act), .tc_o(tc), .irq_o(irq),
    .clk_out_o(clk_out), .frame_end_o(fend)
  );

  int cyc = 0;
  int ntc = 0;
  int nfe = 0;
  int tc_time[1024];
  int checks = 0;
  int fails = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (tc) begin
      if (ntc < 1024) tc_time[ntc] = cyc;
      ntc = ntc + 1;
    end
    if (fend) nfe = nfe + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  function automatic logic [15:0] cw(input int mode, input int src, input bit chtx,
                                     input bit irq_en, input bit dma_en, input bit run);
    return {7'd0, run, dma_en, irq_en, chtx, src[1:0], mode[2:0]};
  endfunction

  task automatic stop_ct();
    wr(3'd0, 16'd0);
    waitn(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, v2, base, w, n0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd2, v); check("R1 count", v, 0);
    rd(3'd3, v); check("R1 capture", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    check("R1 tc_o", int'(tc), 0);
    check("R1 irq_o", int'(irq), 0);
    check("R1 clk_out_o", int'(clk_out), 0);
    check("R1 frame_end_o", int'(fend), 0);

    // R2 / R3 preset sweep, system clock
    for (int p = 0; p < 6; p++) begin
      stop_ct();
      base = ntc;
      wr(3'd1, 16'(p));
      wr(3'd0, cw(0, 0, 0, 0, 0, 1));
      w = cyc;
      rd(3'd2, v); check("R2 count loaded", v, p);
      check("R3 clk_out cleared", int'(clk_out), 0);
      waitn(2*p + 4);
      #1;
      check("R2 first tc", tc_time[base] - w, p + 1);
      check("R2 second tc", tc_time[base+1] - w, 2*p + 2);
      check("R3 clk_out parity", int'(clk_out), (ntc - base) & 1);
    end

    // R12 hold
    stop_ct();
    wr(3'd1, 16'd100);
    wr(3'd0, cw(0, 0, 0, 0, 0, 1));
    waitn(5);
    stop_ct();
    rd(3'd2, v); check("R12 frozen value", v, 93);
    waitn(10);
    rd(3'd2, v2); check("R12 stays frozen", v2, 93);

    // R12 preset change mid-run
    stop_ct();
    base = ntc;
    wr(3'd1, 16'd5);
    wr(3'd0, cw(0, 0, 0, 0, 0, 1));
    w = cyc;
    wr(3'd1, 16'd1);
    waitn(8);
    #1;
    check("R12 old period tc", tc_time[base] - w, 6);
    check("R12 new period tc1", tc_time[base+1] - w, 8);
    check("R12 new period tc2", tc_time[base+2] - w, 10);

    // R4 prescaled source
    stop_ct();
    base = ntc;
    wr(3'd1, 16'd2);
    wr(3'd0, cw(0, 1, 0, 0, 0, 1));
    waitn(9*PRESC + 4);
    #1;
    check("R4 prescaled interval a", tc_time[base+1] - tc_time[base], 3*PRESC);
    check("R4 prescaled interval b", tc_time[base+2] - tc_time[base+1], 3*PRESC);

    // R5 event counting
    stop_ct();
    base = ntc;
    wr(3'd1, 16'd2);
    wr(3'd0, cw(1, 0, 0, 0, 0, 1));
    for (int k = 0; k < 12; k++) begin
      ext_clk = 1'b1; waitn(2);
      ext_clk = 1'b0; waitn(2);
    end
    waitn(6);
    #1;
    check("R5 event tc count", ntc - base, 4);
    rd(3'd2, v); check("R5 event count", v, 2);

    // R6 character counting, receive select
    stop_ct();
    base = ntc;
    wr(3'd1, 16'd3);
    wr(3'd0, cw(2, 0, 0, 0, 0, 1));
    for (int k = 0; k < 8; k++) begin
      rx_ch = 1'b1; waitn(1); rx_ch = 1'b0;
      if (k < 5) begin tx_ch = 1'b1; waitn(1); tx_ch = 1'b0; end
      waitn(1);
    end
    waitn(2);
    #1;
    check("R6 rx tc count", ntc - base, 2);
    rd(3'd2, v); check("R6 rx count", v, 3);

    // R6 transmit select
    stop_ct();
    base = ntc;
    wr(3'd0, cw(2, 0, 1, 0, 0, 1));
    for (int k = 0; k < 9; k++) begin
      rx_ch = 1'b1; waitn(1); rx_ch = 1'b0;
      if (k < 6) begin tx_ch = 1'b1; waitn(1); tx_ch = 1'b0; end
      waitn(1);
    end
    waitn(2);
    #1;
    check("R6 tx tc count", ntc - base, 1);
    rd(3'd2, v); check("R6 tx count", v, 1);

    // R7 one-shot
    stop_ct();
    base = ntc;
    wr(3'd1, 16'd4);
    wr(3'd0, cw(3, 0, 0, 0, 0, 1));
    w = cyc;
    waitn(30);
    #1;
    check("R7 single tc", ntc - base, 1);
    check("R7 tc time", tc_time[base] - w, 5);
    rd(3'd2, v); check("R7 holds zero", v, 0);
    check("R7 clk_out toggled once", int'(clk_out), 1);

    // R8 interval measurement
    stop_ct();
    base = ntc;
    wr(3'd0, cw(4, 0, 0, 0, 0, 1));
    rxd = ~rxd;
    waitn(1);
    for (int j = 0; j < 5; j++) begin
      int gap;
      gap = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 4 : (j == 3) ? 12 : 37;
      waitn(gap);
      rxd = ~rxd;
      waitn(1);
      rd(3'd3, v); check("R8 capture", v, gap);
    end
    #1;
    check("R8 tc per capture", ntc - base, 5);
    waitn(70000);
    rxd = ~rxd;
    waitn(1);
    rd(3'd3, v); check("R8 saturation", v, 65535);

    // R9 / R10 set and clear on the same edge
    stop_ct();
    wr(3'd4, 16'd1);
    wr(3'd1, 16'd3);
    wr(3'd0, cw(0, 0, 0, 1, 0, 1));
    waitn(7);
    wr(3'd4, 16'd1);
    rd(3'd4, v); check("R9 set wins over clear", v, 1);
    check("R10 irq high", int'(irq), 1);
    wr(3'd4, 16'd1);
    rd(3'd4, v); check("R9 cleared", v, 0);
    check("R10 irq low", int'(irq), 0);

    // R10 masked
    stop_ct();
    wr(3'd0, cw(0, 0, 0, 0, 0, 1));
    waitn(10);
    rd(3'd4, v); check("R10 status set while masked", v, 1);
    check("R10 irq masked", int'(irq), 0);

    // R11 frame terminate
    stop_ct();
    dma_act = 1'b1;
    wr(3'd1, 16'd1);
    n0 = nfe;
    wr(3'd0, cw(0, 0, 0, 0, 1, 1));
    waitn(20);
    #1;
    check("R11 frame_end with dma", nfe - n0, 10);
    stop_ct();
    dma_act = 1'b0;
    n0 = nfe;
    wr(3'd0, cw(0, 0, 0, 0, 1, 1));
    waitn(20);
    #1;
    check("R11 frame_end without dma", nfe - n0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule